// File: doc/BRIEF.md
# SCSI Initiator Command and Status Register Block

This block is the byte-wide register front end of a SCSI initiator controller. A host reaches sixteen byte registers spaced four bytes apart: address bits [5:2] pick the register and bits [1:0] are ignored. Reads and writes see different registers at the same index. A read of index 4 returns the status register, while a write to index 4 latches the target number for a later selection. A write to the command register (index 3) is decoded at once. The decoded command updates the status (index 4), interrupt-cause (index 5) and sequence-step (index 6) registers, and it raises the interrupt line. A read of the interrupt-cause register acknowledges the interrupt.

Non-DMA bytes pass through a 32-entry byte FIFO at index 2, and its fill level reads back at index 7. Target selection is reduced to a handshake with the outside. The block checks a vector of present targets. For a present target it issues a one-cycle request, and it waits for an acknowledge that carries a signed transfer length. The sign of that length gives the data direction. Bus signalling and the data transfer engine live elsewhere.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset, or when the rst pin is held, every register reads 0x00 except index 14, which reads 0x04. The interrupt line, the pending flag, the DMA mode flag and the request output are all low, and the FIFO is empty.
- R2: Writes to indices 0, 1, 8, 12, 13, 14 and 15 are stored as written. A write to index 11 is stored as the value AND 0x15. Writes to indices 4, 5, 6, 7, 9 and 10 leave the value read back at that index unchanged.
- R3: A command write stores the whole byte, which reads back at index 3. Bit 7 of the byte sets the DMA mode output, and bits [6:0] are the command code.
- R4: Code 0x01 (flush) sets the interrupt cause to 0x08 and the sequence step to 0, and it does not raise the interrupt.
- R5: Code 0x02 (chip reset) returns every register, the FIFO, the interrupt and the DMA mode to the state given in R1.
- R6: Code 0x03 (bus reset) sets the interrupt cause to 0x80. It raises the interrupt only when bit 6 of index 8 is 0.
- R7: Code 0x42 or 0x43 selects the target held in the written index 4, bits [2:0]. If that target is 4 or higher, or its present bit is 0, the block sets status 0x80, interrupt cause 0x20 and sequence 0, and it raises the interrupt.
- R8: If the selected target is present, cmd_req pulses for one cycle with cmd_target set to that target. Command writes are ignored until cmd_ack arrives. On cmd_ack the interrupt cause becomes 0x18 and the sequence step becomes 4, and the interrupt is raised. The status becomes 0x91 for a positive length and 0x90 for a negative length, and it is left unchanged for a length of zero.
- R9: A read of index 5 clears every status bit except 0x10 and drops irq and dma_pend. If a cmd_ack lands in the same cycle, the acknowledge's results win.
- R10: Code 0x11 raises the interrupt. With bit 7 set, it writes status 0x93, interrupt cause 0x18 and sequence 4. With bit 7 clear, it refills the FIFO with tgt_status followed by 0x00, so index 7 reads 2.
- R11: Code 0x12 acts as in R10, and then sets the interrupt cause to 0x20 and the sequence step to 0.
- R12: Any other code (for example 0x00 or 0x7F) leaves the status, interrupt cause, sequence step and interrupt line unchanged.
- R13: A write to index 2 pushes a byte and a read of index 2 pops the oldest byte. An empty FIFO reads 0x00. Pushes into a full FIFO of 32 bytes are dropped, and index 7 reads the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (applies read side effects) |
| addr | input | 6 | Byte address; bits [5:2] select the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt line |
| dma_pend | output | 1 | DMA-side interrupt pending flag |
| dma_mode | output | 1 | DMA mode taken from command bit 7 |
| tgt_present | input | 4 | One bit per target: device present |
| cmd_req | output | 1 | One-cycle request to issue a command to cmd_target |
| cmd_target | output | 3 | Target number of the pending selection |
| cmd_ack | input | 1 | Command accepted by the target |
| cmd_len | input | 16 | Signed data length returned with cmd_ack |
| tgt_status | input | 8 | Status byte loaded by the response commands |

## Verification
The interrupt acknowledge (a read of index 5) and the end of a selection (cmd_ack) can fall in the same clock cycle. The bench provokes this by pulsing the acknowledge together with a read strobe at index 5 while a selection is pending. It then judges the result: the line must still be high, the status must read 0x91 and the interrupt cause 0x18. In other words, the late event overrides the clearing read. A further checked point is a command write that arrives while the selection is still waiting, which must have no effect.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

    localparam int REG_NUM  = 16;
    localparam int IX_FIFO  = 2;
    localparam int IX_CMD   = 3;
    localparam int IX_STAT  = 4;
    localparam int IX_INTR  = 5;
    localparam int IX_SEQ   = 6;
    localparam int IX_LVL   = 7;
    localparam int IX_CFG   = 8;
    localparam int IX_ID    = 14;

    localparam logic [7:0] CHIP_ID  = 8'h04;
    localparam logic [7:0] ST_IRQ   = 8'h80;
    localparam logic [7:0] ST_TC    = 8'h10;
    localparam logic [7:0] PH_DOUT  = 8'h00;
    localparam logic [7:0] PH_DIN   = 8'h01;
    localparam logic [7:0] PH_STS   = 8'h03;
    localparam logic [7:0] IC_FUNC  = 8'h08;
    localparam logic [7:0] IC_SVC   = 8'h10;
    localparam logic [7:0] IC_DISC  = 8'h20;
    localparam logic [7:0] IC_BRST  = 8'h80;
    localparam logic [7:0] SEQ_DONE = 8'h04;

    typedef enum logic [2:0] {
        CK_OTHER,
        CK_FLUSH,
        CK_CHIPRST,
        CK_BUSRST,
        CK_SELECT,
        CK_RESP,
        CK_MSGACC
    } cmd_kind_e;

    // Bits of a host write that are kept in the read view of a register.
    function automatic logic [7:0] wr_keep_mask(input logic [3:0] ix);
        case (ix)
            4'd0, 4'd1, 4'd8, 4'd12, 4'd13, 4'd14, 4'd15: return 8'hFF;
            4'd11:                                         return 8'h15;
            default:                                       return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/scsi_cmd_dec.sv
module scsi_cmd_dec
    import scsi_ctl_pkg::*;
(
    input  logic [6:0] code,
    output cmd_kind_e  kind
);
    always_comb begin
        case (code)
            7'h01:        kind = CK_FLUSH;
            7'h02:        kind = CK_CHIPRST;
            7'h03:        kind = CK_BUSRST;
            7'h42, 7'h43: kind = CK_SELECT;
            7'h11:        kind = CK_RESP;
            7'h12:        kind = CK_MSGACC;
            default:      kind = CK_OTHER;
        endcase
    end
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load_pair,
    input  logic [W-1:0]  pair_a,
    input  logic [W-1:0]  pair_b,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_push = push && (count < CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (load_pair) begin
            mem[0] <= pair_a;
            mem[1] <= pair_b;
            rptr   <= '0;
            wptr   <= AW'(2);
            count  <= CW'(2);
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
    import scsi_ctl_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int NTGT       = 4,
    parameter int LEN_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [5:0]              addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic                    irq,
    output logic                    dma_pend,
    output logic                    dma_mode,
    input  logic [NTGT-1:0]         tgt_present,
    output logic                    cmd_req,
    output logic [2:0]              cmd_target,
    input  logic                    cmd_ack,
    input  logic signed [LEN_W-1:0] cmd_len,
    input  logic [7:0]              tgt_status
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [7:0]    regs [REG_NUM];
    logic [3:0]    idx;
    logic [2:0]    sel_tgt;
    logic          busy;
    logic          hit;
    logic          cmd_go;
    cmd_kind_e     kind;
    logic          f_clr, f_load, f_push, f_pop;
    logic [7:0]    f_dout;
    logic [CW-1:0] f_cnt;

    assign idx        = addr[5:2];
    assign cmd_go     = wr_en && (idx == 4'(IX_CMD)) && !busy;
    assign cmd_target = sel_tgt;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NTGT; i++)
            if (sel_tgt == 3'(i)) hit = tgt_present[i];
    end

    scsi_cmd_dec u_dec (.code(wdata[6:0]), .kind(kind));

    assign f_clr  = cmd_go && (kind == CK_CHIPRST || kind == CK_SELECT);
    assign f_load = cmd_go && (kind == CK_RESP || kind == CK_MSGACC) && !wdata[7];
    assign f_push = wr_en && (idx == 4'(IX_FIFO));
    assign f_pop  = rd_en && (idx == 4'(IX_FIFO));

    scsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .clr(f_clr), .load_pair(f_load),
        .pair_a(tgt_status), .pair_b(8'h00),
        .push(f_push), .din(wdata), .pop(f_pop),
        .dout(f_dout), .count(f_cnt)
    );

    always_comb begin
        case (idx)
            4'(IX_FIFO): rdata = (f_cnt != '0) ? f_dout : 8'h00;
            4'(IX_LVL):  rdata = 8'(f_cnt);
            default:     rdata = regs[idx];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_NUM; i++)
                regs[i] <= (i == IX_ID) ? CHIP_ID : 8'h00;
            irq      <= 1'b0;
            dma_pend <= 1'b0;
            dma_mode <= 1'b0;
            cmd_req  <= 1'b0;
            busy     <= 1'b0;
            sel_tgt  <= '0;
        end else begin
            cmd_req <= 1'b0;
            // interrupt acknowledge by reading the cause register
            if (rd_en && idx == 4'(IX_INTR)) begin
                regs[IX_STAT] <= regs[IX_STAT] & ST_TC;
                irq           <= 1'b0;
                dma_pend      <= 1'b0;
            end
            if (wr_en && wr_keep_mask(idx) != 8'h00)
                regs[idx] <= wdata & wr_keep_mask(idx);
            if (wr_en && idx == 4'(IX_STAT))
                sel_tgt <= wdata[2:0];
            if (cmd_go) begin
                regs[IX_CMD] <= wdata;
                dma_mode     <= wdata[7];
                case (kind)
                    CK_FLUSH: begin
                        regs[IX_INTR] <= IC_FUNC;
                        regs[IX_SEQ]  <= 8'h00;
                    end
                    CK_CHIPRST: begin
                        for (int i = 0; i < REG_NUM; i++)
                            regs[i] <= (i == IX_ID) ? CHIP_ID : 8'h00;
                        irq      <= 1'b0;
                        dma_pend <= 1'b0;
                        dma_mode <= 1'b0;
                        sel_tgt  <= '0;
                    end
                    CK_BUSRST: begin
                        regs[IX_INTR] <= IC_BRST;
                        if (!regs[IX_CFG][6]) begin
                            irq      <= 1'b1;
                            dma_pend <= 1'b1;
                        end
                    end
                    CK_SELECT: begin
                        if (!hit) begin
                            regs[IX_STAT] <= ST_IRQ;
                            regs[IX_INTR] <= IC_DISC;
                            regs[IX_SEQ]  <= 8'h00;
                            irq           <= 1'b1;
                            dma_pend      <= 1'b1;
                        end else begin
                            busy    <= 1'b1;
                            cmd_req <= 1'b1;
                        end
                    end
                    CK_RESP, CK_MSGACC: begin
                        if (wdata[7]) begin
                            regs[IX_STAT] <= ST_IRQ | ST_TC | PH_STS;
                            regs[IX_INTR] <= IC_SVC | IC_FUNC;
                            regs[IX_SEQ]  <= SEQ_DONE;
                        end
                        if (kind == CK_MSGACC) begin
                            regs[IX_INTR] <= IC_DISC;
                            regs[IX_SEQ]  <= 8'h00;
                        end
                        irq      <= 1'b1;
                        dma_pend <= 1'b1;
                    end
                    default: ;
                endcase
            end
            // target acceptance overrides a same-cycle acknowledge
            if (busy && cmd_ack) begin
                busy <= 1'b0;
                if (cmd_len != '0)
                    regs[IX_STAT] <= ST_IRQ | ST_TC | ((cmd_len > 0) ? PH_DIN : PH_DOUT);
                regs[IX_INTR] <= IC_SVC | IC_FUNC;
                regs[IX_SEQ]  <= SEQ_DONE;
                irq           <= 1'b1;
                dma_pend      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scsi_ctl_regs_chk.sv
module scsi_ctl_regs_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [5:0]    addr,
    input logic [7:0]    wdata,
    input logic          irq,
    input logic          cmd_req,
    input logic          cmd_ack,
    input logic          busy,
    input logic          cfg_mask,
    input logic [CW-1:0] fifo_cnt
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq && !cmd_req)); // R1

    AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[5:2] == 4'd3 && !busy && wdata[6:0] == 7'h03 && cfg_mask && !irq)
        |=> !irq); // R6

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_req |=> !cmd_req); // R8

    AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[5:2] == 4'd5 && !(busy && cmd_ack)) |=> !irq); // R9

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(wr_en) || $past(cmd_ack))); // R12

    AST_FIFO_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && addr[5:2] == 4'd2 && fifo_cnt == CW'(DEPTH))
        |=> (fifo_cnt == CW'(DEPTH))); // R13
endmodule

bind scsi_ctl_regs scsi_ctl_regs_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .irq(irq), .cmd_req(cmd_req), .cmd_ack(cmd_ack),
    .busy(busy), .cfg_mask(regs[8][6]), .fifo_cnt(f_cnt)
);

// File: tb/scsi_ctl_regs_tb_top.sv
module scsi_ctl_regs_tb_top;
    localparam time CLK_P = 10ns;
    localparam int  NVEC  = 20;

    // {req[3:0], op (0 write / 1 read-check), reg[3:0], data[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {4'd1,  1'b1, 4'd14, 8'h04},  // R1 chip id
        {4'd1,  1'b1, 4'd4,  8'h00},  // R1 status
        {4'd2,  1'b0, 4'd0,  8'hA5},
        {4'd2,  1'b1, 4'd0,  8'hA5},  // R2 plain store
        {4'd2,  1'b0, 4'd11, 8'hFF},
        {4'd2,  1'b1, 4'd11, 8'h15},  // R2 masked store
        {4'd2,  1'b0, 4'd13, 8'h3C},
        {4'd2,  1'b1, 4'd13, 8'h3C},  // R2
        {4'd2,  1'b0, 4'd6,  8'h55},
        {4'd2,  1'b1, 4'd6,  8'h00},  // R2 ignored
        {4'd2,  1'b0, 4'd4,  8'h77},
        {4'd2,  1'b1, 4'd4,  8'h00},  // R2 ignored on read side
        {4'd3,  1'b0, 4'd3,  8'h81},
        {4'd3,  1'b1, 4'd3,  8'h81},  // R3 readback
        {4'd4,  1'b1, 4'd5,  8'h08},  // R4 flush cause
        {4'd4,  1'b1, 4'd6,  8'h00},  // R4 sequence
        {4'd12, 1'b0, 4'd3,  8'h7F},
        {4'd12, 1'b1, 4'd5,  8'h08},  // R12 unknown code
        {4'd12, 1'b1, 4'd4,  8'h00},  // R12
        {4'd12, 1'b1, 4'd6,  8'h00}   // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq, dma_pend, dma_mode, cmd_req, cmd_ack = 1'b0;
    logic [3:0]  tgt_present = 4'b0010;
    logic [2:0]  cmd_target;
    logic signed [15:0] cmd_len = '0;
    logic [7:0]  tgt_status = 8'h02;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    scsi_ctl_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .dma_pend(dma_pend),
        .dma_mode(dma_mode), .tgt_present(tgt_present), .cmd_req(cmd_req),
        .cmd_target(cmd_target), .cmd_ack(cmd_ack), .cmd_len(cmd_len),
        .tgt_status(tgt_status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] r, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = {r, 2'b00}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] r, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = {r, 2'b00};
        #1 chk(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 req", {7'd0, cmd_req}, 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][12]) rd($sformatf("R%0d vec%0d", VEC[k][16:13], k), VEC[k][11:8], VEC[k][7:0]);
            else            wr(VEC[k][11:8], VEC[k][7:0]);
        end

        // R3 DMA mode from bit 7
        wr(4'd3, 8'h80);
        chk("R3 dma on", {7'd0, dma_mode}, 8'h01);
        wr(4'd3, 8'h00);
        chk("R3 dma off", {7'd0, dma_mode}, 8'h00);

        // R6 bus reset, unmasked then masked
        wr(4'd8, 8'h00);
        wr(4'd3, 8'h03);
        chk("R6 irq", {7'd0, irq}, 8'h01);
        rd("R6 cause", 4'd5, 8'h80);
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);
        chk("R9 pend cleared", {7'd0, dma_pend}, 8'h00);
        wr(4'd8, 8'h40);
        wr(4'd3, 8'h03);
        chk("R6 masked", {7'd0, irq}, 8'h00);
        wr(4'd8, 8'h00);

        // R7 absent targets
        wr(4'd4, 8'h05);
        wr(4'd3, 8'h42);
        chk("R7 irq", {7'd0, irq}, 8'h01);
        rd("R7 status", 4'd4, 8'h80);
        rd("R7 cause", 4'd5, 8'h20);
        rd("R7 seq", 4'd6, 8'h00);
        wr(4'd4, 8'h00);
        wr(4'd3, 8'h43);
        rd("R7 not present", 4'd5, 8'h20);

        // R8 present target, ack concurrent with interrupt read (R9)
        wr(4'd4, 8'h01);
        wr(4'd3, 8'h42);
        chk("R8 req", {7'd0, cmd_req}, 8'h01);
        chk("R8 target", {5'd0, cmd_target}, 8'h01);
        wr(4'd3, 8'h03);
        chk("R8 busy ignores cmd", {7'd0, irq}, 8'h00);
        @(negedge clk);
        cmd_ack = 1'b1; cmd_len = 16'sd8; rd_en = 1'b1; addr = 6'd20;
        @(negedge clk);
        cmd_ack = 1'b0; rd_en = 1'b0;
        chk("R9 ack wins irq", {7'd0, irq}, 8'h01);
        rd("R8 status in", 4'd4, 8'h91);
        rd("R8 cause", 4'd5, 8'h18);
        rd("R8 seq", 4'd6, 8'h04);
        rd("R9 keeps tc", 4'd4, 8'h10);

        wr(4'd3, 8'h42);
        @(negedge clk);
        cmd_ack = 1'b1; cmd_len = -16'sd3;
        @(negedge clk);
        cmd_ack = 1'b0;
        rd("R8 status out", 4'd4, 8'h90);
        rd("R8 cause out", 4'd5, 8'h18);
        wr(4'd3, 8'h42);
        @(negedge clk);
        cmd_ack = 1'b1; cmd_len = 16'sd0;
        @(negedge clk);
        cmd_ack = 1'b0;
        rd("R8 zero len status", 4'd4, 8'h10);
        rd("R8 zero len cause", 4'd5, 8'h18);

        // R10 / R11 responses
        wr(4'd3, 8'h11);
        chk("R10 irq", {7'd0, irq}, 8'h01);
        rd("R10 level", 4'd7, 8'h02);
        rd("R10 byte0", 4'd2, 8'h02);
        rd("R10 byte1", 4'd2, 8'h00);
        rd("R10 level empty", 4'd7, 8'h00);
        wr(4'd3, 8'h91);
        rd("R10 dma status", 4'd4, 8'h93);
        rd("R10 dma cause", 4'd5, 8'h18);
        rd("R10 dma seq", 4'd6, 8'h04);
        wr(4'd3, 8'h12);
        rd("R11 cause", 4'd5, 8'h20);
        rd("R11 seq", 4'd6, 8'h00);
        rd("R11 level", 4'd7, 8'h02);

        // R5 chip reset
        wr(4'd3, 8'h03);
        wr(4'd3, 8'h02);
        chk("R5 irq", {7'd0, irq}, 8'h00);
        rd("R5 id", 4'd14, 8'h04);
        rd("R5 reg0", 4'd0, 8'h00);
        rd("R5 reg11", 4'd11, 8'h00);
        rd("R5 level", 4'd7, 8'h00);

        // R13 FIFO fill past capacity
        for (int i = 0; i < 34; i++) wr(4'd2, 8'(8'h40 + i));
        rd("R13 full level", 4'd7, 8'd32);
        for (int i = 0; i < 32; i++) rd("R13 pop order", 4'd2, 8'(8'h40 + i));
        rd("R13 empty read", 4'd2, 8'h00);
        rd("R13 empty level", 4'd7, 8'h00);

        // R1 reset pin while active
        wr(4'd3, 8'h03);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 irq after rst", {7'd0, irq}, 8'h00);
        rd("R1 id after rst", 4'd14, 8'h04);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule